// File: doc/BRIEF.md
# Store-to-Load Forwarding Unit

This block keeps a small queue of in-flight stores and answers byte-level forwarding queries from a two-stage load pipeline. Each entry carries the upper bits of a virtual address, the upper bits of a physical address, an 8-lane byte mask, a 64-bit data word, and valid bits for the address and for the data. Three write ports fill entries: one allocates an entry, one supplies its address and mask, and one supplies its data. Allocation and address and data writes may reach an entry in any order after allocation.

A load presents its virtual address, physical address, byte mask and a bitmap that marks which queue entries are older than the load. The bitmap replaces a queue pointer, so the compare path stays short. In the load's first cycle the block returns a fast per-byte coverage mask and a data-not-ready flag. One cycle later it returns the coverage mask, the forwarded bytes, and three hazard flags. The flags are data-not-ready, address-unknown, and disagreement between virtual and physical matching. The first two come with the queue index of the youngest store that caused them. The load pipeline replays the load when data-not-ready or address-unknown is raised, and it flushes the store path on a virtual/physical disagreement.

Top module: `sfwd_unit`

## Requirements
- R1: After reset no entry is allocated, so a load with any older bitmap gets a zero forward mask, zero data and no flag.
- R2: Allocating an entry clears its address-valid and data-valid bits. An address write sets the address, the mask and address-valid. A data write sets the data and data-valid. Every write takes effect from the next cycle. Address and data writes to an entry that is not allocated, and is not being allocated in the same cycle, are ignored.
- R3: An entry takes part in a query only when it is allocated and its bit in ld_older_i is set.
- R4: A participating entry with a valid address hits when the address bits above bit 2 are equal and the store mask ANDed with ld_mask_i is non-zero. The virtual hit and the physical hit are evaluated separately, and forwarding and data-not-ready use the physical hit.
- R5: For each byte lane b (data bits 8b+7..8b), the youngest participating store that has a physical hit and mask bit b set supplies the byte, and fwd_mask_o bit b is set. Lanes that no such store covers have their mask bit at 0 and their data byte at 0x00.
- R6: Age follows the older bitmap, which is taken as a contiguous circular run of entries. The youngest entry is the set bit i whose successor (i+1) mod DEPTH is clear. When every bit is set, entry DEPTH-1 is the youngest.
- R7: fwd_mask_fast_o and data_nrdy_fast_o answer combinationally in the cycle ld_valid_i is high. fwd_mask_o, fwd_data_o and all stage-2 flags and indices appear one cycle later.
- R8: data_nrdy_fast_o, and data_nrdy_o one cycle later, are high when a participating store with a physical hit has no valid data. data_nrdy_idx_o gives the youngest such store.
- R9: addr_unk_o is high in stage 2 when a participating entry has no valid address. addr_unk_idx_o gives the youngest such entry.
- R10: vp_mismatch_o is high in stage 2 when a participating entry with a valid address has a virtual hit that differs from its physical hit.
- R11: With ld_valid_i low, the fast outputs are 0, and in the next cycle every stage-2 output is 0. A reported index is 0 whenever its flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alloc_valid_i | input | 1 | Allocate an entry |
| alloc_idx_i | input | IDX_W | Entry to allocate |
| aw_valid_i | input | 1 | Address write |
| aw_idx_i | input | IDX_W | Entry for the address write |
| aw_va_i | input | VA_W | Store virtual address |
| aw_pa_i | input | PA_W | Store physical address |
| aw_mask_i | input | 8 | Store byte mask |
| dw_valid_i | input | 1 | Data write |
| dw_idx_i | input | IDX_W | Entry for the data write |
| dw_data_i | input | 64 | Store data |
| ld_valid_i | input | 1 | Load query in stage 1 |
| ld_va_i | input | VA_W | Load virtual address |
| ld_pa_i | input | PA_W | Load physical address |
| ld_mask_i | input | 8 | Load byte mask |
| ld_older_i | input | DEPTH | Entries older than the load |
| fwd_mask_fast_o | output | 8 | Stage-1 byte coverage |
| data_nrdy_fast_o | output | 1 | Stage-1 data-not-ready |
| fwd_mask_o | output | 8 | Stage-2 byte coverage |
| fwd_data_o | output | 64 | Stage-2 forwarded bytes |
| data_nrdy_o | output | 1 | Stage-2 data-not-ready |
| data_nrdy_idx_o | output | IDX_W | Youngest store with unready data |
| addr_unk_o | output | 1 | Stage-2 address-unknown |
| addr_unk_idx_o | output | IDX_W | Youngest store with unknown address |
| vp_mismatch_o | output | 1 | Virtual/physical match disagreement |

## Verification
A stale valid bit or payload in an entry stays hidden until a load lists that entry as older. From then on it shows as a wrong byte or a wrong flag. The fast mask shows it in the same cycle and the stage-2 outputs one cycle later. A fault in the age pick shows only when two covering stores overlap on a lane, and most sharply when the older run wraps past the top entry. For that reason the stimulus includes wrapped and full bitmaps. Every query is compared against a model that walks entries from youngest to oldest, so a divergence is caught on the first load that exposes it.

// File: rtl/sfwd_pkg.sv
package sfwd_pkg;
  localparam int unsigned LANES  = 8;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;

  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sfwd_store_array.sv
module sfwd_store_array #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned VA_W  = 39,
  parameter int unsigned PA_W  = 36,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned VT_W  = VA_W - 3,
  localparam int unsigned PT_W  = PA_W - 3
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               alloc_valid_i,
  input  logic [IDX_W-1:0]                   alloc_idx_i,
  input  logic                               aw_valid_i,
  input  logic [IDX_W-1:0]                   aw_idx_i,
  input  logic [VT_W-1:0]                    aw_vtag_i,
  input  logic [PT_W-1:0]                    aw_ptag_i,
  input  sfwd_pkg::lane_mask_t               aw_mask_i,
  input  logic                               dw_valid_i,
  input  logic [IDX_W-1:0]                   dw_idx_i,
  input  sfwd_pkg::word_t                    dw_data_i,
  output logic [DEPTH-1:0]                   alloc_o,
  output logic [DEPTH-1:0]                   addr_vld_o,
  output logic [DEPTH-1:0]                   data_vld_o,
  output logic [DEPTH-1:0][VT_W-1:0]         vtag_o,
  output logic [DEPTH-1:0][PT_W-1:0]         ptag_o,
  output sfwd_pkg::lane_mask_t [DEPTH-1:0]   mask_o,
  output sfwd_pkg::word_t [DEPTH-1:0]        data_o
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic alloc_hit, aw_ok, dw_ok;
    assign alloc_hit = alloc_valid_i && (alloc_idx_i == IDX_W'(i));
    assign aw_ok = aw_valid_i && (aw_idx_i == IDX_W'(i)) && (alloc_o[i] || alloc_hit);
    assign dw_ok = dw_valid_i && (dw_idx_i == IDX_W'(i)) && (alloc_o[i] || alloc_hit);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        alloc_o[i]    <= 1'b0;
        addr_vld_o[i] <= 1'b0;
        data_vld_o[i] <= 1'b0;
      end else begin
        if (alloc_hit) begin
          alloc_o[i]    <= 1'b1;
          addr_vld_o[i] <= 1'b0;
          data_vld_o[i] <= 1'b0;
        end
        if (aw_ok) addr_vld_o[i] <= 1'b1;
        if (dw_ok) data_vld_o[i] <= 1'b1;
      end
    end

    // payload carries no reset; valid bits guard it
    always_ff @(posedge clk_i) begin
      if (aw_ok) begin
        vtag_o[i] <= aw_vtag_i;
        ptag_o[i] <= aw_ptag_i;
        mask_o[i] <= aw_mask_i;
      end
      if (dw_ok) data_o[i] <= dw_data_i;
    end
  end

  a_r2_alloc_clears_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && !(aw_valid_i && aw_idx_i == alloc_idx_i))
      |=> !addr_vld_o[$past(alloc_idx_i)]);

  a_r2_alloc_clears_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && !(dw_valid_i && dw_idx_i == alloc_idx_i))
      |=> !data_vld_o[$past(alloc_idx_i)]);

  a_r2_unalloc_aw_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aw_valid_i && !alloc_o[aw_idx_i] && !(alloc_valid_i && alloc_idx_i == aw_idx_i))
      |=> !addr_vld_o[$past(aw_idx_i)]);

  a_r2_allocated_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_o[alloc_idx_i] |=> alloc_o[$past(alloc_idx_i)]);

endmodule

// File: rtl/sfwd_youngest_pick.sv
// Picks the youngest candidate: highest index inside the low region
// (entries up to the run's end), otherwise highest index overall.
module sfwd_youngest_pick #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] cand_i,
  input  logic [DEPTH-1:0] low_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [DEPTH-1:0] lo, pool;

  always_comb begin
    lo    = cand_i & low_i;
    pool  = (|lo) ? lo : cand_i;
    idx_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (pool[i]) idx_o = IDX_W'(i);
    end
  end

  assign found_o = |cand_i;

  always_comb begin
    if (!$isunknown(cand_i) && !$isunknown(low_i)) begin
      a_r6_pick_is_candidate: assert (!found_o || cand_i[idx_o]);
      a_r6_low_region_first: assert (!(|(cand_i & low_i)) || low_i[idx_o] || !found_o);
    end
  end

endmodule

// File: rtl/sfwd_unit.sv
module sfwd_unit #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned VA_W  = 39,
  parameter int unsigned PA_W  = 36,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LANES = sfwd_pkg::LANES,
  localparam int unsigned VT_W  = VA_W - 3,
  localparam int unsigned PT_W  = PA_W - 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 alloc_valid_i,
  input  logic [IDX_W-1:0]     alloc_idx_i,
  input  logic                 aw_valid_i,
  input  logic [IDX_W-1:0]     aw_idx_i,
  input  logic [VA_W-1:0]      aw_va_i,
  input  logic [PA_W-1:0]      aw_pa_i,
  input  logic [7:0]           aw_mask_i,
  input  logic                 dw_valid_i,
  input  logic [IDX_W-1:0]     dw_idx_i,
  input  logic [63:0]          dw_data_i,
  input  logic                 ld_valid_i,
  input  logic [VA_W-1:0]      ld_va_i,
  input  logic [PA_W-1:0]      ld_pa_i,
  input  logic [7:0]           ld_mask_i,
  input  logic [DEPTH-1:0]     ld_older_i,
  output logic [7:0]           fwd_mask_fast_o,
  output logic                 data_nrdy_fast_o,
  output logic [7:0]           fwd_mask_o,
  output logic [63:0]          fwd_data_o,
  output logic                 data_nrdy_o,
  output logic [IDX_W-1:0]     data_nrdy_idx_o,
  output logic                 addr_unk_o,
  output logic [IDX_W-1:0]     addr_unk_idx_o,
  output logic                 vp_mismatch_o
);
  import sfwd_pkg::*;

  logic [DEPTH-1:0]            ent_alloc, ent_av, ent_dv;
  logic [DEPTH-1:0][VT_W-1:0]  ent_vtag;
  logic [DEPTH-1:0][PT_W-1:0]  ent_ptag;
  lane_mask_t [DEPTH-1:0]      ent_mask;
  word_t [DEPTH-1:0]           ent_data;

  logic unused_low_bits;
  assign unused_low_bits = ^{aw_va_i[2:0], aw_pa_i[2:0], ld_va_i[2:0], ld_pa_i[2:0]};

  sfwd_store_array #(.DEPTH(DEPTH), .VA_W(VA_W), .PA_W(PA_W)) u_array (
    .clk_i, .rst_ni,
    .alloc_valid_i, .alloc_idx_i,
    .aw_valid_i, .aw_idx_i,
    .aw_vtag_i (aw_va_i[VA_W-1:3]),
    .aw_ptag_i (aw_pa_i[PA_W-1:3]),
    .aw_mask_i (aw_mask_i),
    .dw_valid_i, .dw_idx_i,
    .dw_data_i (dw_data_i),
    .alloc_o    (ent_alloc),
    .addr_vld_o (ent_av),
    .data_vld_o (ent_dv),
    .vtag_o     (ent_vtag),
    .ptag_o     (ent_ptag),
    .mask_o     (ent_mask),
    .data_o     (ent_data)
  );

  // participation, hits, age region
  logic [DEPTH-1:0] part, va_hit, pa_hit, run_end, low_reg;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic ovl;
    assign part[i]    = ent_alloc[i] & ld_older_i[i];
    assign ovl        = |(ent_mask[i] & ld_mask_i);
    assign va_hit[i]  = ovl && (ent_vtag[i] == ld_va_i[VA_W-1:3]);
    assign pa_hit[i]  = ovl && (ent_ptag[i] == ld_pa_i[PA_W-1:3]);
    assign run_end[i] = ld_older_i[i] & ~ld_older_i[(i + 1) % DEPTH];
    assign low_reg[i] = |run_end[DEPTH-1:i];
  end

  logic [DEPTH-1:0] fwd_base, nrdy_cand, unk_cand, mm_vec;
  assign fwd_base  = part & ent_av & pa_hit;
  assign nrdy_cand = fwd_base & ~ent_dv;
  assign unk_cand  = part & ~ent_av;
  assign mm_vec    = part & ent_av & (va_hit ^ pa_hit);

  // per-lane youngest covering store
  lane_mask_t             lane_found;
  logic [LANES-1:0][7:0]  lane_byte;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [DEPTH-1:0] cand;
    logic [IDX_W-1:0] idx;
    for (genvar i = 0; i < DEPTH; i++) begin : g_c
      assign cand[i] = fwd_base[i] & ent_mask[i][b];
    end
    sfwd_youngest_pick #(.DEPTH(DEPTH)) u_pick (
      .cand_i (cand), .low_i (low_reg), .found_o (lane_found[b]), .idx_o (idx)
    );
    assign lane_byte[b] = lane_found[b] ? ent_data[idx][8*b +: 8] : 8'h00;
  end

  logic             nrdy_found, unk_found;
  logic [IDX_W-1:0] nrdy_idx, unk_idx;

  sfwd_youngest_pick #(.DEPTH(DEPTH)) u_pick_nrdy (
    .cand_i (nrdy_cand), .low_i (low_reg), .found_o (nrdy_found), .idx_o (nrdy_idx)
  );
  sfwd_youngest_pick #(.DEPTH(DEPTH)) u_pick_unk (
    .cand_i (unk_cand), .low_i (low_reg), .found_o (unk_found), .idx_o (unk_idx)
  );

  // stage 1
  assign fwd_mask_fast_o  = ld_valid_i ? lane_found : '0;
  assign data_nrdy_fast_o = ld_valid_i & nrdy_found;

  // stage 2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_mask_o      <= '0;
      fwd_data_o      <= '0;
      data_nrdy_o     <= 1'b0;
      data_nrdy_idx_o <= '0;
      addr_unk_o      <= 1'b0;
      addr_unk_idx_o  <= '0;
      vp_mismatch_o   <= 1'b0;
    end else begin
      fwd_mask_o      <= ld_valid_i ? lane_found : '0;
      fwd_data_o      <= ld_valid_i ? lane_byte : '0;
      data_nrdy_o     <= ld_valid_i & nrdy_found;
      data_nrdy_idx_o <= (ld_valid_i & nrdy_found) ? nrdy_idx : '0;
      addr_unk_o      <= ld_valid_i & unk_found;
      addr_unk_idx_o  <= (ld_valid_i & unk_found) ? unk_idx : '0;
      vp_mismatch_o   <= ld_valid_i & (|mm_vec);
    end
  end

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_i |=> (fwd_mask_o == '0 && fwd_data_o == '0 && !data_nrdy_o
                     && !addr_unk_o && !vp_mismatch_o));

  a_r7_fast_then_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |=> (fwd_mask_o == $past(fwd_mask_fast_o)));

  a_r8_nrdy_repeats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |=> (data_nrdy_o == $past(data_nrdy_fast_o)));

  a_r9_unk_idx_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_unk_o |-> addr_unk_idx_o == '0);

  a_r8_nrdy_idx_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_nrdy_o |-> data_nrdy_idx_o == '0);

  a_r5_uncovered_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_mask_o == '0) |-> (fwd_data_o == '0));

endmodule

// File: tb/tb_sfwd_unit.sv
module tb_sfwd_unit;
  localparam int D = 16;

  logic clk = 0, rst_ni = 0;
  always #4 clk = ~clk;

  logic        alloc_valid_i = 0, aw_valid_i = 0, dw_valid_i = 0, ld_valid_i = 0;
  logic [3:0]  alloc_idx_i = 0, aw_idx_i = 0, dw_idx_i = 0;
  logic [38:0] aw_va_i = 0, ld_va_i = 0;
  logic [35:0] aw_pa_i = 0, ld_pa_i = 0;
  logic [7:0]  aw_mask_i = 0, ld_mask_i = 0;
  logic [63:0] dw_data_i = 0;
  logic [D-1:0] ld_older_i = 0;
  logic [7:0]  fwd_mask_fast_o, fwd_mask_o;
  logic        data_nrdy_fast_o, data_nrdy_o, addr_unk_o, vp_mismatch_o;
  logic [63:0] fwd_data_o;
  logic [3:0]  data_nrdy_idx_o, addr_unk_idx_o;

  sfwd_unit #(.DEPTH(D), .VA_W(39), .PA_W(36)) dut (
    .clk_i(clk), .rst_ni,
    .alloc_valid_i, .alloc_idx_i, .aw_valid_i, .aw_idx_i, .aw_va_i, .aw_pa_i, .aw_mask_i,
    .dw_valid_i, .dw_idx_i, .dw_data_i,
    .ld_valid_i, .ld_va_i, .ld_pa_i, .ld_mask_i, .ld_older_i,
    .fwd_mask_fast_o, .data_nrdy_fast_o, .fwd_mask_o, .fwd_data_o,
    .data_nrdy_o, .data_nrdy_idx_o, .addr_unk_o, .addr_unk_idx_o, .vp_mismatch_o
  );

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model
  bit         m_alloc[D], m_av[D], m_dv[D];
  logic [38:0] m_va[D];
  logic [35:0] m_pa[D];
  logic [7:0]  m_mask[D];
  logic [63:0] m_data[D];

  typedef struct {
    logic [7:0] mask; logic [63:0] data;
    bit nrdy; logic [3:0] nrdy_idx; bit unk; logic [3:0] unk_idx; bit mm;
  } res_t;

  function automatic res_t model(input logic [38:0] va, input logic [35:0] pa,
                                 input logic [7:0] lm, input logic [D-1:0] older);
    res_t r;
    int e = D - 1;
    r.mask = 0; r.data = 0; r.nrdy = 0; r.nrdy_idx = 0; r.unk = 0; r.unk_idx = 0; r.mm = 0;
    for (int i = 0; i < D; i++) if (older[i] && !older[(i+1)%D]) e = i;
    for (int k = 0; k < D; k++) begin
      int j = (e - k + D) % D;
      bit vh, ph;
      if (!(m_alloc[j] && older[j])) continue;
      if (!m_av[j]) begin
        if (!r.unk) begin r.unk = 1; r.unk_idx = 4'(j); end
        continue;
      end
      vh = ((m_va[j] >> 3) == (va >> 3)) && ((m_mask[j] & lm) != 0);
      ph = ((m_pa[j] >> 3) == (pa >> 3)) && ((m_mask[j] & lm) != 0);
      if (vh != ph) r.mm = 1;
      if (!ph) continue;
      if (!m_dv[j] && !r.nrdy) begin r.nrdy = 1; r.nrdy_idx = 4'(j); end
      for (int b = 0; b < 8; b++)
        if (m_mask[j][b] && !r.mask[b]) begin
          r.mask[b] = 1; r.data[8*b +: 8] = m_data[j][8*b +: 8];
        end
    end
    return r;
  endfunction

  bit   pend = 0;
  res_t pexp;
  string ptag;

  task automatic check_s2();
    if (pend) begin
      chk(fwd_mask_o == pexp.mask, ptag, "R5 fwd_mask", 64'(fwd_mask_o), 64'(pexp.mask));
      chk(fwd_data_o == pexp.data, ptag, "R5 fwd_data", fwd_data_o, pexp.data);
      chk(data_nrdy_o == pexp.nrdy && data_nrdy_idx_o == pexp.nrdy_idx, ptag, "R8 nrdy/idx",
          {59'd0, data_nrdy_o, data_nrdy_idx_o}, {59'd0, pexp.nrdy, pexp.nrdy_idx});
      chk(addr_unk_o == pexp.unk && addr_unk_idx_o == pexp.unk_idx, ptag, "R9 unk/idx",
          {59'd0, addr_unk_o, addr_unk_idx_o}, {59'd0, pexp.unk, pexp.unk_idx});
      chk(vp_mismatch_o == pexp.mm, ptag, "R10 mismatch", 64'(vp_mismatch_o), 64'(pexp.mm));
      pend = 0;
    end
  endtask

  // op: 0 alloc, 1 addr write, 2 data write, 3 load
  task automatic step(input int op, input logic [3:0] idx, input logic [38:0] va,
                      input logic [35:0] pa, input logic [7:0] mask,
                      input logic [63:0] data, input logic [D-1:0] older, input string tag);
    @(negedge clk);
    check_s2();
    alloc_valid_i = 0; aw_valid_i = 0; dw_valid_i = 0; ld_valid_i = 0;
    case (op)
      0: begin
        alloc_valid_i = 1; alloc_idx_i = idx;
        m_alloc[idx] = 1; m_av[idx] = 0; m_dv[idx] = 0;
      end
      1: begin
        aw_valid_i = 1; aw_idx_i = idx; aw_va_i = va; aw_pa_i = pa; aw_mask_i = mask;
        if (m_alloc[idx]) begin m_av[idx] = 1; m_va[idx] = va; m_pa[idx] = pa; m_mask[idx] = mask; end
      end
      2: begin
        dw_valid_i = 1; dw_idx_i = idx; dw_data_i = data;
        if (m_alloc[idx]) begin m_dv[idx] = 1; m_data[idx] = data; end
      end
      3: begin
        ld_valid_i = 1; ld_va_i = va; ld_pa_i = pa; ld_mask_i = mask; ld_older_i = older;
        pexp = model(va, pa, mask, older);
        #1;
        chk(fwd_mask_fast_o == pexp.mask, tag, "R7 fast mask", 64'(fwd_mask_fast_o), 64'(pexp.mask));
        chk(data_nrdy_fast_o == pexp.nrdy, tag, "R8 fast nrdy", 64'(data_nrdy_fast_o), 64'(pexp.nrdy));
        ptag = tag; pend = 1;
      end
      default: begin
        // idle: R11 expects quiet outputs
        #1;
        chk(fwd_mask_fast_o == 0 && !data_nrdy_fast_o, tag, "R11 fast idle",
            {55'd0, data_nrdy_fast_o, fwd_mask_fast_o}, 64'd0);
        pexp = '{mask:0, data:0, nrdy:0, nrdy_idx:0, unk:0, unk_idx:0, mm:0};
        ptag = tag; pend = 1;
      end
    endcase
  endtask

  typedef struct packed {
    logic [1:0] op; logic [3:0] idx; logic [38:0] va; logic [35:0] pa;
    logic [7:0] mask; logic [63:0] data; logic [15:0] older;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 4'd0, 39'h0, 36'h0, 8'h00, 64'h0, 16'h0},
    '{2'd0, 4'd1, 39'h0, 36'h0, 8'h00, 64'h0, 16'h0},
    '{2'd0, 4'd2, 39'h0, 36'h0, 8'h00, 64'h0, 16'h0},
    '{2'd0, 4'd3, 39'h0, 36'h0, 8'h00, 64'h0, 16'h0},
    '{2'd1, 4'd0, 39'h1000, 36'h8000, 8'h0F, 64'h0, 16'h0},
    '{2'd2, 4'd0, 39'h0, 36'h0, 8'h00, 64'h1111111111111111, 16'h0},
    '{2'd3, 4'd0, 39'h1000, 36'h8000, 8'hFF, 64'h0, 16'h0001},     // R3 only entry 0
    '{2'd3, 4'd0, 39'h1004, 36'h8004, 8'hFF, 64'h0, 16'h000F},     // R9 youngest unknown = 3
    '{2'd1, 4'd1, 39'h1000, 36'h8000, 8'h3C, 64'h0, 16'h0},
    '{2'd3, 4'd0, 39'h1000, 36'h8000, 8'hFF, 64'h0, 16'h0003},     // R8 entry 1 not ready
    '{2'd2, 4'd1, 39'h0, 36'h0, 8'h00, 64'h2222222222222222, 16'h0},
    '{2'd3, 4'd0, 39'h1000, 36'h8000, 8'hFF, 64'h0, 16'h0003},     // R5 partial overlap
    '{2'd3, 4'd0, 39'h1000, 36'h8000, 8'h0C, 64'h0, 16'h0003},
    '{2'd1, 4'd2, 39'h1008, 36'h8008, 8'hFF, 64'h0, 16'h0},
    '{2'd1, 4'd3, 39'h1000, 36'h9000, 8'hFF, 64'h0, 16'h0},
    '{2'd2, 4'd2, 39'h0, 36'h0, 8'h00, 64'h3333333333333333, 16'h0},
    '{2'd2, 4'd3, 39'h0, 36'h0, 8'h00, 64'h4444444444444444, 16'h0},
    '{2'd3, 4'd0, 39'h1000, 36'h8000, 8'hFF, 64'h0, 16'h000F},     // R10 entry 3 va-only hit
    '{2'd3, 4'd0, 39'h1000, 36'h8000, 8'hC0, 64'h0, 16'h0003},     // R4 no mask overlap
    '{2'd3, 4'd0, 39'h1008, 36'h8008, 8'h81, 64'h0, 16'h0007},     // R4 other dword
    '{2'd0, 4'd15, 39'h0, 36'h0, 8'h00, 64'h0, 16'h0},
    '{2'd1, 4'd15, 39'h1000, 36'h8000, 8'hFF, 64'h0, 16'h0},
    '{2'd2, 4'd15, 39'h0, 36'h0, 8'h00, 64'hFFEEDDCCBBAA9988, 16'h0},
    '{2'd3, 4'd0, 39'h1000, 36'h8000, 8'hFF, 64'h0, 16'h8003},     // R6 wrap, youngest = 1
    '{2'd3, 4'd0, 39'h1000, 36'h8000, 8'hFF, 64'h0, 16'hFFFF},     // R6 full, youngest = 15
    '{2'd3, 4'd0, 39'h1000, 36'h8000, 8'hFF, 64'h0, 16'hC000},     // R3 14 unallocated
    '{2'd0, 4'd1, 39'h0, 36'h0, 8'h00, 64'h0, 16'h0},
    '{2'd3, 4'd0, 39'h1000, 36'h8000, 8'hFF, 64'h0, 16'h0003},     // R2 realloc clears
    '{2'd1, 4'd5, 39'h1000, 36'h8000, 8'hFF, 64'h0, 16'h0},        // R2 ignored write
    '{2'd2, 4'd5, 39'h0, 36'h0, 8'h00, 64'h5555555555555555, 16'h0},
    '{2'd0, 4'd5, 39'h0, 36'h0, 8'h00, 64'h0, 16'h0},
    '{2'd3, 4'd0, 39'h1000, 36'h8000, 8'hFF, 64'h0, 16'h0020}      // R2 entry 5 still unknown
  };

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) begin
      m_alloc[i] = 0; m_av[i] = 0; m_dv[i] = 0;
      m_va[i] = 0; m_pa[i] = 0; m_mask[i] = 0; m_data[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    chk(fwd_mask_o == 0 && !data_nrdy_o && !addr_unk_o && !vp_mismatch_o, "R1", "reset outputs",
        {53'd0, fwd_mask_o, data_nrdy_o, addr_unk_o, vp_mismatch_o}, 64'd0);
    step(3, 0, 39'h1000, 36'h8000, 8'hFF, 0, 16'hFFFF, "R1 empty queue");

    for (int n = 0; n < NV; n++)
      step(int'(TBL[n].op), TBL[n].idx, TBL[n].va, TBL[n].pa, TBL[n].mask,
           TBL[n].data, TBL[n].older, $sformatf("R5 table[%0d]", n));

    step(4, 0, 0, 0, 0, 0, 0, "R11 idle");

    for (int n = 0; n < 600; n++) begin
      int r = $urandom % 11;
      int sel = $urandom % 3;
      int psel = ($urandom % 8 == 0) ? ($urandom % 3) : sel;
      logic [D-1:0] older = 0;
      int s = $urandom % D;
      int len = 1 + ($urandom % D);
      for (int k = 0; k < len; k++) older[(s + k) % D] = 1'b1;
      case (r)
        0, 1: step(0, 4'($urandom), 0, 0, 0, 0, 0, "R2 rand");
        2, 3, 4: step(1, 4'($urandom), 39'h1000 + 39'(8*sel) + 39'($urandom % 8),
                      36'h8000 + 36'(8*psel), 8'($urandom), 0, 0, "R2 rand");
        5, 6: step(2, 4'($urandom), 0, 0, 0, {$urandom, $urandom}, 0, "R2 rand");
        10: step(4, 0, 0, 0, 0, 0, 0, "R11 rand idle");
        default: step(3, 0, 39'h1000 + 39'(8*sel), 36'h8000 + 36'(8*sel), 8'($urandom),
                      0, older, "R6 rand load");
      endcase
    end

    @(negedge clk);
    check_s2();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule